// File: doc/BRIEF.md
# Oversampled Right-Justified Audio Transmitter

This block drives a serial two-channel audio link towards a pair of DACs. It generates an output bit clock and a word clock from one core clock. It shifts one parallel stereo sample per word period out on two data lines, one per channel, MSB first, with the LSB right-justified against the end of the word. The word rate is four or eight times the audio sample rate. The bit-clock rate follows from the system-clock multiple that the core clock represents. Each word is cut down to a programmable length by keeping its upper bits.

`clkCore` runs at twice the audio system clock, so a bit clock equal to the system clock can still be built from registers. A sample is handed over with a one-cycle `sampleValid` strobe. The word that starts after the current word ends carries it. If no new sample arrives, the last one is sent again. After reset the outputs stay parked at fixed levels for an initialisation window of `INIT_SYS_CLKS` system clocks before the first word begins.

Top module: `ovs_rj_tx`

## Requirements
- R1: The bit-clock period in core cycles is 2 for `ratioSel` codes 0 (128 fs), 1 (192 fs) and 2 (256 fs), 4 for codes 3 (384 fs) and 4 (512 fs), and 8 for code 5 (768 fs). Codes 6 and 7 behave as code 2. `bitClk` is low for the first half of each period and high for the second half.
- R2: The number of bit slots per word is 32 for code 0, 48 for code 1, 32 or 64 for codes 2 and 4, and 24 or 48 for codes 3 and 5. For codes 2 to 5 the first value applies with `os4x`=0 (8x) and the second with `os4x`=1 (4x).
- R3: Codes 0 and 1 always run at 4x, whatever `os4x` is.
- R4: `wlenSel` 0, 1, 2 and 3 select 16, 18, 20 and 24 output bits. The sent word is the upper that-many bits of the 24-bit two's-complement sample, MSB first. Left and right are sent on `dataL` and `dataR` in the same slots.
- R5: The LSB sits in the last slot of the word. All slots ahead of the MSB carry 0.
- R6: `wordClk` is high for the first half of the word's slots and low for the second half. `wordClk` and the data lines change only together with a falling edge of `bitClk`.
- R7: `sampleL`/`sampleR` are captured only in a cycle with `sampleValid`=1. A word period without a new sample repeats the last captured sample, and sample inputs without the strobe have no effect.
- R8: `ratioSel`, `os4x` and `wlenSel` are taken up only at word boundaries. A change made during a word takes effect from the next word, and the word in progress keeps its timing.
- R9: While `rstN` is low, and for 2*`INIT_SYS_CLKS` core cycles after its release, `bitClk`, `dataL` and `dataR` are held low and `wordClk` high. The first word then starts, and the first `bitClk` rise is registered on core edge 2*`INIT_SYS_CLKS`+1+P/2 after release, where P is the bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkCore | input | 1 | Core clock, twice the system-clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioSel | input | 3 | System-clock multiple code (R1) |
| os4x | input | 1 | 1 selects 4x word rate, 0 selects 8x |
| wlenSel | input | 2 | Output word-length code (R4) |
| sampleValid | input | 1 | One-cycle strobe that captures a new stereo sample |
| sampleL | input | DATA_W | Left sample, two's complement |
| sampleR | input | DATA_W | Right sample, two's complement |
| bitClk | output | 1 | Output bit clock |
| wordClk | output | 1 | Output word clock |
| dataL | output | 1 | Left serial data |
| dataR | output | 1 | Right serial data |

## Verification
The bench walks through every clock-ratio code, both oversampling settings and every word length, including the 64-slot word where 48 leading zeros precede a 16-bit value. A shifted count of padding slots would show up as a wrong decoded value. A wrong divider would show up as a wrong rise-to-rise bit period or slot count. Codes 0 and 1 are driven with 8x requested; a design that honoured that request would produce half the expected slot count. Configuration changes are made mid-word and word periods without a strobe carry scrambled inputs. Early adoption would corrupt the word in progress, and a leaky capture would change the repeated value. Two resets at different ratios check the parked levels and the exact edge of the first bit-clock rise, which exposes an off-by-one initialisation counter.

// File: rtl/ovs_rj_tx_pkg.sv
package ovs_rj_tx_pkg;

  localparam int SLOT_W = 7;  // holds slot indices up to 127
  localparam int PH_W   = 3;  // holds bit phases up to 7

  typedef struct packed {
    logic initActive;  // outputs parked
    logic loadWord;    // take new sample and configuration
    logic bitStart;    // first core cycle of a bit slot
    logic leadSlot;    // current slot precedes the MSB
    logic bitHigh;     // bit clock high phase
    logic wordHigh;    // word clock high half
  } txStrobe_t;

  // last phase index of a bit period (period minus one)
  function automatic logic [PH_W-1:0] bitDivLast(input logic [2:0] ratio);
    case (ratio)
      3'd3, 3'd4: return PH_W'(3);
      3'd5:       return PH_W'(7);
      default:    return PH_W'(1);
    endcase
  endfunction

  // last slot index of a word (slot count minus one)
  function automatic logic [SLOT_W-1:0] slotLast(input logic [2:0] ratio, input logic os4);
    case (ratio)
      3'd0:       return SLOT_W'(31);
      3'd1:       return SLOT_W'(47);
      3'd3, 3'd5: return os4 ? SLOT_W'(47) : SLOT_W'(23);
      default:    return os4 ? SLOT_W'(63) : SLOT_W'(31);
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] wordBits(input logic [1:0] wlen);
    case (wlen)
      2'd0:    return SLOT_W'(16);
      2'd1:    return SLOT_W'(18);
      2'd2:    return SLOT_W'(20);
      default: return SLOT_W'(24);
    endcase
  endfunction

endpackage

// File: rtl/ovs_rj_tx_ctrl.sv
module ovs_rj_tx_ctrl
  import ovs_rj_tx_pkg::*;
#(
  parameter int INIT_SYS_CLKS = 1024
) (
  input  logic      clkCore,
  input  logic      rstN,
  input  logic [2:0] ratioSel,
  input  logic      os4x,
  input  logic [1:0] wlenSel,
  output txStrobe_t strobe
);

  localparam int INIT_CORE = 2 * INIT_SYS_CLKS;
  localparam int INIT_W    = $clog2(INIT_CORE + 1);

  logic [INIT_W-1:0] initCnt;
  logic              initActive;
  logic [2:0]        ratioQ;
  logic              os4Q;
  logic [1:0]        wlenQ;
  logic [PH_W-1:0]   ph;
  logic [SLOT_W-1:0] sl;
  logic [PH_W-1:0]   divLast;
  logic [SLOT_W-1:0] slotLastV;
  logic [SLOT_W-1:0] leadCnt;
  logic              wordEnd;
  logic              loadWord;

  assign initActive = (initCnt != INIT_W'(INIT_CORE));

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN)           initCnt <= '0;
    else if (initActive) initCnt <= initCnt + 1'b1;
  end

  assign divLast   = bitDivLast(ratioQ);
  assign slotLastV = slotLast(ratioQ, os4Q);
  assign leadCnt   = slotLastV + SLOT_W'(1) - wordBits(wlenQ);
  assign wordEnd   = !initActive && (ph == divLast) && (sl == slotLastV);
  assign loadWord  = initActive || wordEnd;

  // configuration is adopted only between words
  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN) begin
      ratioQ <= 3'd2;
      os4Q   <= 1'b0;
      wlenQ  <= 2'd0;
    end else if (loadWord) begin
      ratioQ <= ratioSel;
      os4Q   <= os4x;
      wlenQ  <= wlenSel;
    end
  end

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN) begin
      ph <= '0;
      sl <= '0;
    end else if (initActive) begin
      ph <= '0;
      sl <= '0;
    end else if (ph == divLast) begin
      ph <= '0;
      sl <= (sl == slotLastV) ? '0 : sl + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign strobe.initActive = initActive;
  assign strobe.loadWord   = loadWord;
  assign strobe.bitStart   = !initActive && (ph == '0);
  assign strobe.leadSlot   = (sl < leadCnt);
  assign strobe.bitHigh    = (ph > (divLast >> 1));
  assign strobe.wordHigh   = (sl <= (slotLastV >> 1));

endmodule

// File: rtl/ovs_rj_tx_dpath.sv
module ovs_rj_tx_dpath
  import ovs_rj_tx_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clkCore,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  output logic              bitClk,
  output logic              wordClk,
  output logic              dataL,
  output logic              dataR
);

  logic [DATA_W-1:0] holdL, holdR;
  logic [DATA_W-1:0] txL, txR;

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN) begin
      holdL <= '0;
      holdR <= '0;
    end else if (sampleValid) begin
      holdL <= sampleL;
      holdR <= sampleR;
    end
  end

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN) begin
      txL <= '0;
      txR <= '0;
    end else if (strobe.loadWord) begin
      txL <= holdL;
      txR <= holdR;
    end else if (strobe.bitStart && !strobe.leadSlot) begin
      txL <= txL << 1;
      txR <= txR << 1;
    end
  end

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN) begin
      bitClk  <= 1'b0;
      wordClk <= 1'b1;
      dataL   <= 1'b0;
      dataR   <= 1'b0;
    end else if (strobe.initActive) begin
      bitClk  <= 1'b0;
      wordClk <= 1'b1;
      dataL   <= 1'b0;
      dataR   <= 1'b0;
    end else begin
      bitClk <= strobe.bitHigh;
      if (strobe.bitStart) begin
        wordClk <= strobe.wordHigh;
        dataL   <= strobe.leadSlot ? 1'b0 : txL[DATA_W-1];
        dataR   <= strobe.leadSlot ? 1'b0 : txR[DATA_W-1];
      end
    end
  end

endmodule

// File: rtl/ovs_rj_tx.sv
module ovs_rj_tx
  import ovs_rj_tx_pkg::*;
#(
  parameter int DATA_W        = 24,
  parameter int INIT_SYS_CLKS = 1024
) (
  input  logic              clkCore,
  input  logic              rstN,
  input  logic [2:0]        ratioSel,
  input  logic              os4x,
  input  logic [1:0]        wlenSel,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  output logic              bitClk,
  output logic              wordClk,
  output logic              dataL,
  output logic              dataR
);

  txStrobe_t strobe;

  ovs_rj_tx_ctrl #(.INIT_SYS_CLKS(INIT_SYS_CLKS)) u_ctrl (
    .clkCore (clkCore),
    .rstN    (rstN),
    .ratioSel(ratioSel),
    .os4x    (os4x),
    .wlenSel (wlenSel),
    .strobe  (strobe)
  );

  ovs_rj_tx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clkCore    (clkCore),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleValid(sampleValid),
    .sampleL    (sampleL),
    .sampleR    (sampleR),
    .bitClk     (bitClk),
    .wordClk    (wordClk),
    .dataL      (dataL),
    .dataR      (dataR)
  );

endmodule

// File: rtl/ovs_rj_tx_chk.sv
module ovs_rj_tx_chk #(
  parameter int INIT_SYS_CLKS = 1024
) (
  input logic clkCore,
  input logic rstN,
  input logic bitClk,
  input logic wordClk,
  input logic dataL,
  input logic dataR
);

  localparam int INIT_CORE = 2 * INIT_SYS_CLKS;
  localparam int CNT_W     = $clog2(INIT_CORE + 3);

  logic [CNT_W-1:0] relCnt;
  logic [3:0]       hiCnt;

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN)                                 relCnt <= '0;
    else if (relCnt != CNT_W'(INIT_CORE + 2))  relCnt <= relCnt + 1'b1;
  end

  always_ff @(posedge clkCore or negedge rstN) begin
    if (!rstN)                      hiCnt <= '0;
    else if (!bitClk)               hiCnt <= '0;
    else if (hiCnt != 4'hF)         hiCnt <= hiCnt + 1'b1;
  end

  AST_INIT_PARKED: assert property (@(posedge clkCore) disable iff (!rstN)
    (relCnt < CNT_W'(INIT_CORE)) |-> (!bitClk && wordClk && !dataL && !dataR)); // R9

  AST_BCLK_HIGH_BOUNDED: assert property (@(posedge clkCore) disable iff (!rstN)
    hiCnt <= 4'd4); // R1

  AST_WCLK_ON_BCLK_FALL: assert property (@(posedge clkCore) disable iff (!rstN)
    ((relCnt > CNT_W'(INIT_CORE + 1)) && !$stable(wordClk)) |-> $fell(bitClk)); // R6

  AST_DATA_ON_BCLK_FALL: assert property (@(posedge clkCore) disable iff (!rstN)
    ((relCnt > CNT_W'(INIT_CORE + 1)) && (!$stable(dataL) || !$stable(dataR))) |-> $fell(bitClk)); // R6

endmodule

bind ovs_rj_tx ovs_rj_tx_chk #(.INIT_SYS_CLKS(INIT_SYS_CLKS)) u_chk (
  .clkCore(clkCore),
  .rstN   (rstN),
  .bitClk (bitClk),
  .wordClk(wordClk),
  .dataL  (dataL),
  .dataR  (dataR)
);

// File: tb/test_ovs_rj_tx.sv
module test_ovs_rj_tx;

  localparam int INIT_SYS  = 1024;
  localparam int INIT_CORE = 2 * INIT_SYS;

  logic        clkCore = 1'b0;
  logic        rstN;
  logic [2:0]  ratioSel;
  logic        os4x;
  logic [1:0]  wlenSel;
  logic        sampleValid;
  logic [23:0] sampleL, sampleR;
  logic        bitClk, wordClk, dataL, dataR;

  always #10 clkCore = ~clkCore;  // 50 MHz

  ovs_rj_tx i_ovs_rj_tx (
    .clkCore(clkCore), .rstN(rstN), .ratioSel(ratioSel), .os4x(os4x),
    .wlenSel(wlenSel), .sampleValid(sampleValid), .sampleL(sampleL),
    .sampleR(sampleR), .bitClk(bitClk), .wordClk(wordClk),
    .dataL(dataL), .dataR(dataR)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expectations derived from the requirements
  function automatic int expSlots(input logic [2:0] r, input bit o);
    case (r)
      3'd0: return 32;
      3'd1: return 48;
      3'd3, 3'd5: return o ? 48 : 24;
      default: return o ? 64 : 32;
    endcase
  endfunction

  function automatic int expPeriod(input logic [2:0] r);
    case (r)
      3'd3, 3'd4: return 4;
      3'd5: return 8;
      default: return 2;
    endcase
  endfunction

  function automatic int expLen(input logic [1:0] w);
    case (w)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  // scoreboard queues, one entry per expected word
  logic [23:0] qL[$], qR[$];
  int          qB[$], qD[$], qLen[$];
  string       qTag[$];

  bit          monOn = 1'b0;
  bit          started = 1'b0;
  bit          prevWc = 1'b1, prevBc = 1'b0;
  bit          perBad;
  int          cyc = 0, lastRise = 0, nBits = 0, nHigh = 0;
  logic [63:0] rxL, rxR;

  task automatic finishWord();
    logic [23:0] eL, eR;
    int b, d, len;
    string tag;
    eL = qL.pop_front(); eR = qR.pop_front();
    b = qB.pop_front(); d = qD.pop_front(); len = qLen.pop_front();
    tag = qTag.pop_front();
    check(nBits == b, {"R2 ", tag}, "slots per word", nBits, b);
    check(nHigh == b / 2, "R6", "slots with word clock high", nHigh, b / 2);
    check(!perBad, {"R1 ", tag}, "bit period within word", perBad, d);
    check(rxL == 64'(eL >> (24 - len)), {"R4 R5 left ", tag}, "word value", rxL, 64'(eL >> (24 - len)));
    check(rxR == 64'(eR >> (24 - len)), {"R4 R5 right ", tag}, "word value", rxR, 64'(eR >> (24 - len)));
  endtask

  // monitor: decodes words from the serial outputs
  always @(negedge clkCore) begin
    cyc++;
    if (!monOn) begin
      started = 1'b0;
    end else begin
      if (wordClk && !prevWc) begin
        if (started) finishWord();
        started = 1'b1;
        nBits = 0; nHigh = 0; rxL = '0; rxR = '0; perBad = 1'b0;
      end
      if (bitClk && !prevBc && started) begin
        if (nBits > 0 && (cyc - lastRise) != qD[0]) perBad = 1'b1;
        rxL = {rxL[62:0], dataL};
        rxR = {rxR[62:0], dataR};
        nBits++;
        if (wordClk) nHigh++;
        lastRise = cyc;
      end
    end
    prevWc = wordClk;
    prevBc = bitClk;
  end

  logic [31:0] seed = 32'h1234_5678;
  logic [23:0] lastL = '0, lastR = '0;

  function automatic logic [23:0] nextVal();
    seed = seed * 32'h41C6_4E6D + 32'd12345;
    return seed[30:7];
  endfunction

  // driver: at the start of a word, set config and optionally give a sample
  task automatic doWord(input logic [2:0] r, input bit o, input logic [1:0] w,
                        input bit give, input string tag);
    @(posedge wordClk);
    @(negedge clkCore);
    ratioSel = r; os4x = o; wlenSel = w;
    if (give) begin
      lastL = nextVal(); lastR = nextVal();
      sampleL = lastL; sampleR = lastR;
      sampleValid = 1'b1;
      @(negedge clkCore);
      sampleValid = 1'b0;
    end
    sampleL = nextVal(); sampleR = nextVal();  // noise without strobe (R7)
    qL.push_back(lastL); qR.push_back(lastR);
    qB.push_back(expSlots(r, o)); qD.push_back(expPeriod(r));
    qLen.push_back(expLen(w)); qTag.push_back(tag);
  endtask

  task automatic checkInReset();
    check(!bitClk && wordClk && !dataL && !dataR, "R9", "levels in reset",
          {bitClk, wordClk, dataL, dataR}, 4'b0100);
  endtask

  task automatic releaseAndCheck(input int d);
    int n = 0, firstHigh = 0;
    bit bad = 1'b0;
    rstN = 1'b1;
    while (firstHigh == 0 && n < INIT_CORE + 40) begin
      @(negedge clkCore);
      n++;
      if (bitClk) firstHigh = n;
      else if (n <= INIT_CORE && (!wordClk || dataL || dataR)) bad = 1'b1;
    end
    check(!bad, "R9", "parked levels in window", bad, 0);
    check(firstHigh == INIT_CORE + 1 + d / 2, "R9", "edge of first bit clock rise",
          firstHigh, INIT_CORE + 1 + d / 2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clkCore);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ratioSel = 3'd2; os4x = 1'b0; wlenSel = 2'd3;
    sampleValid = 1'b0; sampleL = '0; sampleR = '0;
    repeat (5) @(negedge clkCore);
    checkInReset();
    // first decoded word carries the reset value of the hold registers
    qL.push_back('0); qR.push_back('0); qB.push_back(32); qD.push_back(2);
    qLen.push_back(24); qTag.push_back("");
    monOn = 1'b1;
    releaseAndCheck(2);

    doWord(3'd2, 1'b0, 2'd3, 1'b1, "");
    doWord(3'd2, 1'b0, 2'd3, 1'b1, "");
    doWord(3'd2, 1'b0, 2'd3, 1'b1, "");
    doWord(3'd2, 1'b0, 2'd3, 1'b0, "R7");
    doWord(3'd5, 1'b0, 2'd3, 1'b1, "R8");
    doWord(3'd5, 1'b0, 2'd3, 1'b1, "");
    doWord(3'd5, 1'b0, 2'd3, 1'b0, "R7");
    doWord(3'd0, 1'b0, 2'd0, 1'b1, "R3 R8");
    doWord(3'd0, 1'b0, 2'd0, 1'b1, "R3");
    doWord(3'd1, 1'b0, 2'd1, 1'b1, "R3 R8");
    doWord(3'd1, 1'b0, 2'd1, 1'b0, "R3 R7");
    doWord(3'd3, 1'b1, 2'd2, 1'b1, "R8");
    doWord(3'd3, 1'b1, 2'd2, 1'b1, "");
    doWord(3'd4, 1'b1, 2'd0, 1'b1, "R8");
    doWord(3'd4, 1'b1, 2'd0, 1'b1, "");
    doWord(3'd2, 1'b1, 2'd1, 1'b1, "R8");
    doWord(3'd2, 1'b1, 2'd1, 1'b1, "");
    repeat (2) begin
      @(posedge wordClk);
      @(negedge clkCore);
      @(negedge clkCore);
    end
    monOn = 1'b0;
    qL.delete(); qR.delete(); qB.delete(); qD.delete(); qLen.delete(); qTag.delete();

    // second reset at a different ratio
    ratioSel = 3'd5; os4x = 1'b0;
    @(negedge clkCore);
    rstN = 1'b0;
    repeat (3) @(negedge clkCore);
    checkInReset();
    releaseAndCheck(8);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule